// File: doc/BRIEF.md
# Prescaled Dual-Counter Pulse-Width Modulator

This block produces a pulse-width modulated output from two cascaded 8-bit counters. A prescaler counter advances on every machine-cycle tick and, whenever it passes its all-ones value, reloads from a programmable reload register. Each such overflow advances the modulation counter by one. The output rises when the modulation counter wraps from all ones to zero and falls when it reaches the active width value. This gives a duty cycle of width/256 and a period of 256 × (256 − reload) ticks.

The width value is double-buffered. A write lands in a buffer that is visible at once through the read port. The comparator only takes the buffered value at the next wrap of the modulation counter, so no period is ever cut short or stretched by a mid-period update. The machine-cycle tick comes from outside: typically one pulse every 12 input clocks, or every 6 in double-speed operation. A single enable gates the whole function.

Top module: `dual_counter_pwm`

## Requirements
- R1: While enabled, the prescaler advances on each `mc_tick`. On the tick where it holds FFh it reloads from the reload register and signals one overflow, so overflows recur every (256 − reload) ticks. The first overflow after enabling comes 256 ticks in, because the prescaler starts at 00h.
- R2: Reload FFh gives an overflow on every tick. Reload 00h gives one overflow per 256 ticks.
- R3: The modulation counter increments by one on each prescaler overflow, so the output period is 256 × (256 − reload) ticks.
- R4: When the modulation counter wraps from FFh to 00h, `pwm_out` goes high, unless R6 applies.
- R5: When the modulation counter reaches the active width, `pwm_out` goes low. The high time is therefore width × (256 − reload) ticks.
- R6: When the wrap and the width match fall in the same cycle (active width 00h), the clear wins and `pwm_out` stays low.
- R7: A width write (`wr_sel`=1) only becomes the active width at the next FFh-to-00h wrap. The pulse in progress keeps the old width.
- R8: `rd_data` is registered from `rd_sel` (0 = reload register, 1 = width buffer). One cycle after a write, it returns the newly written value, even before that value is active.
- R9: While `en` is low, `pwm_out` is low from the next cycle and both counters are held at 00h. After `en` rises, with one tick per clock, the first rising edge comes 256 + 255 × (256 − reload) clocks later.
- R10: Synchronous reset clears the reload register, the width buffer, the active width, both counters, `pwm_out` and `rd_data`.
- R11: The counters change only on cycles with `mc_tick` high. With a tick every N clocks, all times scale by N (N = 12 or 6 for a machine cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Modulator enable |
| mc_tick | input | 1 | Machine-cycle tick, one clock wide |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 reload, 1 width |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 reload, 1 width buffer |
| rd_data | output | 8 | Registered read data |
| pwm_out | output | 1 | Modulated output, registered |

## Verification
The assertions check several rules on every cycle. Each prescaler overflow reloads the counter, and a cycle without a tick leaves it unchanged. A disable forces the output low and the counters to zero. The active width moves only at a wrap. A zero active width keeps the output low. Every rising edge lines up with a zero count, and every enabled falling edge lines up with a width match. Only the bench scenarios show the timing seen from outside: the measured high and period lengths for several reload, width and tick-spacing combinations, the delayed take-over of a width written mid-pulse, the immediate read-back, and the latency from enable to the first pulse.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;
  typedef enum logic {
    SEL_RELOAD = 1'b0,
    SEL_WIDTH  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dcpwm_regs.sv
module dcpwm_regs
  import dcpwm_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  output logic [CW-1:0] reload_q,
  output logic [CW-1:0] width_buf_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q    <= '0;
      width_buf_q <= '0;
      rd_data     <= '0;
    end else begin
      if (wr_en && reg_sel_e'(wr_sel) == SEL_RELOAD) reload_q <= wr_data;
      if (wr_en && reg_sel_e'(wr_sel) == SEL_WIDTH)  width_buf_q <= wr_data;
      rd_data <= (reg_sel_e'(rd_sel) == SEL_WIDTH) ? width_buf_q : reload_q;
    end
  end

  // R8: one cycle after a write, the selected register holds the written data
  assert_write_lands_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel) |=> (width_buf_q == $past(wr_data)));
endmodule

// File: rtl/dcpwm_prescaler.sv
module dcpwm_prescaler #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] reload,
  output logic          ovf
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q;

  assign ovf = en && tick && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt_q <= '0;
    else if (ovf)    cnt_q <= reload;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  // R1 / R2: every overflow restarts the count at the reload value
  assert_reload_on_ovf_R1: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt_q == $past(reload)));
  // R11: no tick, no movement
  assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/dcpwm_modcore.sv
module dcpwm_modcore #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ovf,
  input  logic [CW-1:0] width_buf,
  output logic          pwm_out
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] cnt_q, act_q, nxt_cnt, nxt_act;
  logic          wrap;

  always_comb begin
    wrap    = ovf && (cnt_q == TOP);
    nxt_cnt = cnt_q + 1'b1;
    nxt_act = wrap ? width_buf : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      act_q   <= '0;
      pwm_out <= 1'b0;
    end else begin
      if (wrap) act_q <= width_buf;
      if (!en) begin
        cnt_q   <= '0;
        pwm_out <= 1'b0;
      end else if (ovf) begin
        cnt_q <= nxt_cnt;
        if (nxt_cnt == nxt_act) pwm_out <= 1'b0;
        else if (wrap)          pwm_out <= 1'b1;
      end
    end
  end

  // R9: disable clears the output and the counter
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_out && cnt_q == '0));
  // R7: the active width only moves at a wrap
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_q));
  // R6: a zero active width never lets the output high
  assert_zero_width_low_R6: assert property (@(posedge clk) disable iff (rst)
    (act_q == '0) |-> !pwm_out);
  // R4: output rises only together with the counter wrap
  assert_rise_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> (cnt_q == '0));
  // R5: an enabled fall lines up with the width match
  assert_fall_at_match_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwm_out) && $past(en)) |-> (cnt_q == act_q));
endmodule

// File: rtl/dual_counter_pwm.sv
module dual_counter_pwm #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          mc_tick,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic          rd_sel,
  output logic [CW-1:0] rd_data,
  output logic          pwm_out
);
  logic [CW-1:0] reload_q, width_buf_q;
  logic          pre_ovf;

  dcpwm_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .reload_q(reload_q),
    .width_buf_q(width_buf_q)
  );

  dcpwm_prescaler #(.CW(CW)) u_pre (
    .clk(clk), .rst(rst), .en(en), .tick(mc_tick), .reload(reload_q),
    .ovf(pre_ovf)
  );

  dcpwm_modcore #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .en(en), .ovf(pre_ovf), .width_buf(width_buf_q),
    .pwm_out(pwm_out)
  );
endmodule

// File: tb/test_dual_counter_pwm.sv
module test_dual_counter_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = 80000;
  localparam int NV = 8;
  localparam logic [7:0] V_RLD [NV] = '{8'hFF, 8'hFE, 8'hFF, 8'hFF, 8'hFC, 8'hFF, 8'hFF, 8'h00};
  localparam logic [7:0] V_WID [NV] = '{8'h80, 8'h40, 8'hFF, 8'h01, 8'h10, 8'h20, 8'h20, 8'h01};
  localparam int V_DIV [NV] = '{1, 1, 1, 1, 3, 12, 6, 1};
  localparam int V_HI  [NV] = '{128, 128, 255, 1, 192, 384, 192, 256};
  localparam int V_PER [NV] = '{256, 512, 256, 256, 3072, 3072, 1536, 0};

  logic clk = 0, rst = 1, en = 0, mc_tick = 0, wr_en = 0, wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic pwm_out;
  int tick_div = 1;
  int checks = 0, failures = 0;

  dual_counter_pwm i_dual_counter_pwm (
    .clk(clk), .rst(rst), .en(en), .mc_tick(mc_tick), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .pwm_out(pwm_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : tickgen
    int divc;
    divc = 0;
    forever begin
      @(negedge clk);
      divc = (divc + 1 >= tick_div) ? 0 : divc + 1;
      mc_tick = (divc == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic measure(input bit do_per, output int hi, output int per);
    int n;
    n = 0; hi = 0; per = 0;
    while (pwm_out !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
    while (pwm_out === 1'b1 && n < LIM) begin hi++; @(negedge clk); n++; end
    per = hi;
    if (do_per)
      while (pwm_out !== 1'b1 && n < LIM) begin per++; @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int hi, per, n;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state
    chk(pwm_out == 0, "R10 out after reset", pwm_out, 0);
    chk(rd_data == 0, "R10 reload readback", rd_data, 0);
    rd_sel = 1; @(negedge clk);
    chk(rd_data == 0, "R10 width readback", rd_data, 0);

    // R8: reload readback one cycle after write
    rd_sel = 0;
    wr(1'b0, 8'h5A);
    @(negedge clk);
    chk(rd_data == 8'h5A, "R8 reload readback", rd_data, 8'h5A);

    // Table: R1 R2 R3 R4 R5 R11 timing
    for (int i = 0; i < NV; i++) begin
      en = 0; @(negedge clk);
      wr(1'b0, V_RLD[i]);
      wr(1'b1, V_WID[i]);
      tick_div = V_DIV[i];
      en = 1;
      measure(V_PER[i] != 0, hi, per);
      chk(hi == V_HI[i], $sformatf("R1 R2 R5 R11 high time vec %0d", i), hi, V_HI[i]);
      if (V_PER[i] != 0)
        chk(per == V_PER[i], $sformatf("R1 R3 R4 R11 period vec %0d", i), per, V_PER[i]);
    end

    // R7 / R8: width written mid-pulse
    en = 0; tick_div = 1; @(negedge clk);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h80);
    rd_sel = 1;
    en = 1;
    measure(1'b1, hi, per);     // returns on a rising sample
    hi = 1;
    wr(1'b1, 8'h20);
    if (pwm_out) hi++;
    @(negedge clk);
    chk(rd_data == 8'h20, "R8 width readback before apply", rd_data, 8'h20);
    if (pwm_out) hi++;
    while (pwm_out === 1'b1 && hi < 1000) begin @(negedge clk); if (pwm_out) hi++; end
    chk(hi == 128, "R7 pulse in progress keeps old width", hi, 128);
    measure(1'b1, hi, per);
    chk(hi == 32, "R7 new width after wrap", hi, 32);
    chk(per == 256, "R3 period after width change", per, 256);

    // R9: disable while high
    while (pwm_out !== 1'b1) @(negedge clk);
    en = 0; @(negedge clk);
    chk(pwm_out == 0, "R9 output low after disable", pwm_out, 0);
    // R9: counters restart from zero
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h10);
    en = 1; n = 0;
    while (pwm_out !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(n == 511, "R9 first rise latency after enable", n, 511);

    // R6: zero width never goes high
    en = 0; @(negedge clk);
    wr(1'b1, 8'h00);
    en = 1; hi = 0;
    repeat (1300) begin @(negedge clk); if (pwm_out) hi++; end
    chk(hi == 0, "R6 zero width stays low", hi, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule